// File: doc/BRIEF.md
# Round-Robin Interrupt Vector Selector

This block picks one interrupt to service from a wide set of request lines, with no line favoured over another. Each cycle it takes a raw status vector of `WIDTH` bits (32 or 64) and combines it with an internal enable register of the same width. The lines that are both raised and enabled form the pending set. When a dispatch request arrives, the block searches the pending set. The search begins at a stored pointer, and the first pending line found is the winner. The pointer then moves to the line just after the winner, so every raised line is served in turn.

The winning index becomes a vector number. Indices inside a window set by parameters can be folded into a separate external vector space. All other indices are offset into the internal vector space. The enable register starts at all zeros. Software-style commands change one bit at a time: an enable command sets bit n, and a disable command clears bit n.

Top module: `rr_vector_select`

## Requirements
- R1: A status bit whose enable bit is 0 is never selected; only bits set in both status and the enable register count as pending.
- R2: A dispatch request with no pending bit gives `vec_valid`=0 in the following cycle and leaves the search pointer where it was.
- R3: A dispatch request picks the first pending index found when counting upward from the pointer. The pointer then becomes that index plus one.
- R4: With `CASC_EN`=1 and a chosen index i where `CASC_LO` <= i <= `CASC_HI`, the vector is `EXT_BASE` + (i - `CASC_LO`). Any other index gives `INT_BASE` + i.
- R5: A disable command for line n clears only bit n of `mask_q`. An enable command for line n sets only bit n.
- R6: An enable command and a disable command on the same bit in the same cycle leave the bit set. On different bits, both take effect.
- R7: The result is registered. `vec_valid` and `vec_num` appear on the clock edge after the dispatch request, and `vec_valid` stays high for exactly one cycle per request.
- R8: After reset, `vec_valid`=0, `mask_q`=0 and the search pointer is 0.
- R9: The pointer wraps modulo `WIDTH`. After the top index is chosen, the search resumes at index 0.
- R10: A dispatch uses the enable register as it stood before any command issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| status | input | WIDTH | Raw interrupt status lines |
| dispatch | input | 1 | Request to select one pending line |
| dis_en | input | 1 | Disable command strobe |
| dis_idx | input | log2(WIDTH) | Line cleared by the disable command |
| ena_en | input | 1 | Enable command strobe |
| ena_idx | input | log2(WIDTH) | Line set by the enable command |
| vec_valid | output | 1 | One-cycle flag for a selected vector |
| vec_num | output | VEC_W | Selected vector number |
| mask_q | output | WIDTH | Current enable register |

## Verification
Two kinds of input can arrive in the same cycle: a dispatch request and a command that changes the enable register. The bench raises a dispatch in the same cycle as an enable command on a line that is raised but not yet enabled. The result must ignore that line, and the line must appear in `mask_q` one cycle later. The same clash is then applied to the two commands themselves. An enable command and a disable command are aimed at one bit, and `mask_q` must show the bit set.

// File: rtl/rr_vector_select.sv
module rr_vector_select #(
  parameter int WIDTH    = 32,
  parameter int VEC_W    = 8,
  parameter int INT_BASE = 8,
  parameter int EXT_BASE = 80,
  parameter bit CASC_EN  = 1'b1,
  parameter int CASC_LO  = 20,
  parameter int CASC_HI  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         status,
  input  logic                     dispatch,
  input  logic                     dis_en,
  input  logic [$clog2(WIDTH)-1:0] dis_idx,
  input  logic                     ena_en,
  input  logic [$clog2(WIDTH)-1:0] ena_idx,
  output logic                     vec_valid,
  output logic [VEC_W-1:0]         vec_num,
  output logic [WIDTH-1:0]         mask_q
);
  // WIDTH must be a power of two (32 or 64) so the pointer wraps by truncation
  localparam int IW = $clog2(WIDTH);

  logic [WIDTH-1:0] pending;
  logic [WIDTH-1:0] mask_nxt;
  logic [IW-1:0]    ptr_q;
  logic [IW-1:0]    offset;
  logic [IW-1:0]    sel;
  logic             found;
  logic             in_win;
  logic [VEC_W-1:0] vec_map;

  assign pending = status & mask_q;

  always_comb begin
    found  = 1'b0;
    offset = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (pending[ptr_q + IW'(k)]) begin
        found  = 1'b1;
        offset = IW'(k);
      end
    end
  end

  assign sel     = ptr_q + offset;
  assign in_win  = CASC_EN && (int'(sel) >= CASC_LO) && (int'(sel) <= CASC_HI);
  assign vec_map = in_win ? VEC_W'(EXT_BASE + int'(sel) - CASC_LO)
                          : VEC_W'(INT_BASE + int'(sel));

  always_comb begin
    mask_nxt = mask_q;
    if (dis_en) mask_nxt[dis_idx] = 1'b0;
    if (ena_en) mask_nxt[ena_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      ptr_q     <= '0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else begin
      mask_q    <= mask_nxt;
      vec_valid <= dispatch && found;
      if (dispatch && found) begin
        vec_num <= vec_map;
        ptr_q   <= sel + IW'(1);
      end
    end
  end
endmodule

module rr_vector_select_chk #(
  parameter int WIDTH    = 32,
  parameter int VEC_W    = 8,
  parameter int INT_BASE = 8,
  parameter int EXT_BASE = 80,
  parameter bit CASC_EN  = 1'b1,
  parameter int CASC_LO  = 20,
  parameter int CASC_HI  = 23
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         status,
  input logic                     dispatch,
  input logic                     dis_en,
  input logic [$clog2(WIDTH)-1:0] dis_idx,
  input logic                     ena_en,
  input logic [$clog2(WIDTH)-1:0] ena_idx,
  input logic                     vec_valid,
  input logic [VEC_W-1:0]         vec_num,
  input logic [WIDTH-1:0]         mask_q
);
  assert_idle_no_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dispatch || (status & mask_q) == '0) |=> !vec_valid);

  assert_pending_gives_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && (status & mask_q) != '0) |=> vec_valid);

  assert_vec_in_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((int'(vec_num) >= INT_BASE && int'(vec_num) < INT_BASE + WIDTH) ||
                   (CASC_EN && int'(vec_num) >= EXT_BASE &&
                    int'(vec_num) <= EXT_BASE + CASC_HI - CASC_LO)));

  assert_enable_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ena_en |=> mask_q[$past(ena_idx)]);

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_en && !(ena_en && ena_idx == dis_idx)) |=> !mask_q[$past(dis_idx)]);

  assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_en && !ena_en) |=> $stable(mask_q));

  assert_one_bit_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_en ^ ena_en) |=> $countones(mask_q ^ $past(mask_q)) <= 1);
endmodule

bind rr_vector_select rr_vector_select_chk #(
  .WIDTH(WIDTH), .VEC_W(VEC_W), .INT_BASE(INT_BASE), .EXT_BASE(EXT_BASE),
  .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .dispatch(dispatch),
  .dis_en(dis_en), .dis_idx(dis_idx), .ena_en(ena_en), .ena_idx(ena_idx),
  .vec_valid(vec_valid), .vec_num(vec_num), .mask_q(mask_q)
);

// File: tb/rr_vector_select_bench.sv
module rr_vector_select_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  status = '0;
  logic          dispatch = 1'b0;
  logic          dis_en = 1'b0;
  logic [4:0]    dis_idx = '0;
  logic          ena_en = 1'b0;
  logic [4:0]    ena_idx = '0;
  logic          vec_valid;
  logic [7:0]    vec_num;
  logic [W-1:0]  mask_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] m_mask = '0;
  int m_ptr = 0;

  always #5 clk = ~clk;

  rr_vector_select #(.WIDTH(W), .VEC_W(8), .INT_BASE(8), .EXT_BASE(80),
                     .CASC_EN(1'b1), .CASC_LO(20), .CASC_HI(23)) u_rr_vector_select (
    .clk(clk), .rst_n(rst_n), .status(status), .dispatch(dispatch),
    .dis_en(dis_en), .dis_idx(dis_idx), .ena_en(ena_en), .ena_idx(ena_idx),
    .vec_valid(vec_valid), .vec_num(vec_num), .mask_q(mask_q));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int map_vec(input int i);
    if (i >= 20 && i <= 23) return 80 + i - 20;
    return 8 + i;
  endfunction

  // one cycle of stimulus; checks vector result and enable register afterwards
  task automatic step(input logic [W-1:0] st, input bit dsp,
                      input bit ce, input int ci, input bit se, input int si,
                      input string req);
    bit ok = 0;
    int idx = 0;
    logic [W-1:0] pend;
    @(negedge clk);
    status = st; dispatch = dsp;
    dis_en = ce; dis_idx = 5'(ci); ena_en = se; ena_idx = 5'(si);
    pend = st & m_mask;  // R10: old mask
    for (int k = 0; k < W; k++) begin
      if (!ok && pend[(m_ptr + k) % W]) begin ok = 1; idx = (m_ptr + k) % W; end
    end
    if (ce) m_mask[ci] = 1'b0;
    if (se) m_mask[si] = 1'b1;
    @(negedge clk);
    dispatch = 0; dis_en = 0; ena_en = 0;
    if (dsp) begin
      chk(vec_valid == (dsp && ok), req, vec_valid, ok);
      if (ok) begin
        chk(vec_num == 8'(map_vec(idx)), req, vec_num, map_vec(idx));
        m_ptr = (idx + 1) % W;
      end
    end
    chk(mask_q == m_mask, {req, " mask R5"}, mask_q, m_mask);
  endtask

  task automatic t_reset;
    chk(vec_valid == 0, "R8 valid", vec_valid, 0);
    chk(mask_q == '0, "R8 mask", mask_q, 0);
  endtask

  task automatic t_mask_cmds;
    step('0, 0, 0, 0, 1, 3, "R5 set3");
    step('0, 0, 0, 0, 1, 5, "R5 set5");
    step('0, 0, 0, 0, 1, 31, "R5 set31");
    step('0, 0, 1, 5, 0, 0, "R5 clr5");
    step('0, 0, 0, 0, 1, 5, "R5 set5b");
  endtask

  task automatic t_same_bit;
    step('0, 0, 1, 7, 1, 7, "R6 same");
    chk(mask_q[7] == 1, "R6 bit7", mask_q[7], 1);
    step('0, 0, 1, 7, 1, 9, "R6 diff");
    chk(mask_q[7] == 0 && mask_q[9] == 1, "R6 both", mask_q, m_mask);
  endtask

  task automatic t_masked(input string r);
    step(32'h0000_000A, 1, 0, 0, 0, 0, r);  // bit1 masked, bit3 enabled
    chk(vec_num == 8'd11, "R1 pick3", vec_num, 11);
  endtask

  task automatic t_round_robin;
    logic [W-1:0] st = (32'h1 << 3) | (32'h1 << 5) | (32'h1 << 31);
    step(st, 1, 0, 0, 0, 0, "R3 first");
    step(st, 1, 0, 0, 0, 0, "R3 second");
    chk(vec_num == 8'd39, "R9 top", vec_num, 39);
    step(st, 1, 0, 0, 0, 0, "R9 wrap");
    chk(vec_num == 8'd11, "R9 wrapto3", vec_num, 11);
  endtask

  task automatic t_empty;
    step('0, 1, 0, 0, 0, 0, "R2 empty");
    step(32'h1 << 1, 1, 0, 0, 0, 0, "R2 masked only");
    step((32'h1 << 3) | (32'h1 << 5), 1, 0, 0, 0, 0, "R2 ptr kept");
    chk(vec_num == 8'd13, "R2 resumes at 5", vec_num, 13);
  endtask

  task automatic t_cascade;
    for (int b = 19; b <= 24; b++) step('0, 0, 0, 0, 1, b, "R4 enable");
    step(32'h1 << 22, 1, 0, 0, 0, 0, "R4 mid");
    chk(vec_num == 8'd82, "R4 ext22", vec_num, 82);
    step(32'h1 << 20, 1, 0, 0, 0, 0, "R4 lo");
    step(32'h1 << 23, 1, 0, 0, 0, 0, "R4 hi");
    step(32'h1 << 19, 1, 0, 0, 0, 0, "R4 below");
    chk(vec_num == 8'd27, "R4 int19", vec_num, 27);
    step(32'h1 << 24, 1, 0, 0, 0, 0, "R4 above");
  endtask

  task automatic t_clash;
    step(32'h1 << 12, 1, 0, 0, 1, 12, "R10 clash");
    chk(vec_valid == 0, "R10 not yet", vec_valid, 0);
    step(32'h1 << 12, 1, 0, 0, 0, 0, "R10 after");
    chk(vec_num == 8'd20, "R10 picked12", vec_num, 20);
  endtask

  task automatic t_pulse;
    @(negedge clk);
    status = 32'h1 << 3; dispatch = 1;
    @(negedge clk);
    dispatch = 0;
    chk(vec_valid == 1, "R7 up", vec_valid, 1);
    @(negedge clk);
    chk(vec_valid == 0, "R7 one cycle", vec_valid, 0);
    m_ptr = 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_mask_cmds();
    t_same_bit();
    t_masked("R1 masked");
    t_round_robin();
    t_empty();
    t_cascade();
    t_clash();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule